// File: doc/BRIEF.md
# Unaligned Load Alignment Unit

This unit sits between a load requester and a memory that can only be read as whole, aligned 4-byte words. The requester offers a 16-bit byte address and gets back a 4-byte value, as though memory were byte-addressable. When the address is word-aligned, one word read is enough. When it is not, a mode input sets the policy.

There are three policies. In split mode the unit reads two consecutive words. It drops the low bytes of the first word and the high bytes of the second, then joins the two parts. In fault mode the unit reports a misalignment fault and touches no memory. In truncate mode the unit clears the two low address bits and does a single aligned read.

Every response reports how many word reads the load used. The memory has a one-cycle registered read latency. Requests use a valid/ready handshake, and each response is a one-cycle valid pulse.

Top module: `split_load_unit`

## Requirements
- R1: While reset is held (active-low `rst_n`) and directly after it, `req_ready` is 1, and `rsp_valid` and `mem_en` are 0.
- R2: A load from an aligned address (address bits [1:0] = 0), in any mode, does one memory read of word `addr[15:2]`. Its response comes one cycle after acceptance, with the data word, `rsp_fault`=0 and `rsp_count`=1.
- R3: In split mode (`req_mode`=2'b00) a misaligned load does two reads. The first read is word `addr[15:2]` in the acceptance cycle and the second is the next word in the following cycle. The response comes two cycles after acceptance, with `rsp_count`=2 and `rsp_fault`=0.
- R4: The result is little-endian. Bits [8k+7:8k] hold the byte at address addr+k, for k = 0..3. Within a word, byte address offset j sits at bits [8j+7:8j].
- R5: In fault mode (`req_mode`=2'b01) a misaligned load issues no memory read. Its response comes one cycle after acceptance, with `rsp_fault`=1, `rsp_data`=0 and `rsp_count`=0.
- R6: In truncate mode (`req_mode`=2'b10 or 2'b11) a misaligned load does one read of word `addr[15:2]`. Its response comes one cycle after acceptance, with that word as data, `rsp_fault`=0 and `rsp_count`=1.
- R7: `req_ready` is 0 from acceptance until the response cycle has passed. `rsp_valid` is high for exactly one cycle per load.
- R8: In split mode a misaligned address in the last word (0xFFFD to 0xFFFF) wraps its second read to word 0, and bytes past 0xFFFF come from addresses 0x0000 upward.
- R9: The address and mode are captured at acceptance. Changing `req_addr` or `req_mode` afterwards does not change the reads or the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Load request offered |
| req_ready | output | 1 | Unit idle, request can be accepted |
| req_addr | input | 16 | Byte address of the load |
| req_mode | input | 2 | Misalignment policy: 00 split, 01 fault, 1x truncate |
| mem_en | output | 1 | Word read strobe |
| mem_addr | output | 14 | Word index of the read |
| mem_rdata | input | 32 | Read word, valid the cycle after `mem_en` |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | 32 | Loaded value, little-endian |
| rsp_fault | output | 1 | Misalignment fault |
| rsp_count | output | 2 | Number of word reads the load used |

## Verification
The hardest case to reach from the ports is the split load at the top of the address space. There the second read must wrap to word 0 while the merge still uses the captured offset, even though the requester has already moved its address. Directed loads at 0xFFFD, 0xFFFE and 0xFFFF check the wrap. Every load is followed, one cycle after acceptance, by a random new address and mode on the request inputs. Random loads across all offsets and all three policies are mixed in, and each one is compared with a byte-level model of memory. The bench also counts the read strobes it sees during each load.

// File: rtl/split_load_unit.sv
module split_load_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [15:0] req_addr,
  input  logic [1:0]  req_mode,
  output logic        mem_en,
  output logic [13:0] mem_addr,
  input  logic [31:0] mem_rdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_data,
  output logic        rsp_fault,
  output logic [1:0]  rsp_count
);
  typedef enum logic [2:0] {S_IDLE, S_ONE, S_FIRST, S_SECOND, S_FLT} st_t;

  st_t         st, st_n;
  logic [13:0] word_q;
  logic [1:0]  off_q;
  logic [31:0] low_q;
  logic [31:0] joined;

  wire accept   = req_valid && req_ready;
  wire misal    = req_addr[1:0] != 2'b00;
  wire to_fault = misal && req_mode == 2'b01;
  wire to_split = misal && req_mode == 2'b00;

  assign req_ready = st == S_IDLE;
  assign mem_en    = (accept && !to_fault) || st == S_FIRST;
  assign mem_addr  = (st == S_FIRST) ? word_q + 14'd1 : req_addr[15:2];

  always_comb begin
    st_n = S_IDLE;
    case (st)
      S_IDLE:  if (accept) st_n = to_fault ? S_FLT : (to_split ? S_FIRST : S_ONE);
      S_FIRST: st_n = S_SECOND;
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      word_q <= '0;
      off_q  <= '0;
      low_q  <= '0;
    end else begin
      st <= st_n;
      if (accept) begin
        word_q <= req_addr[15:2];
        off_q  <= req_addr[1:0];
      end
      if (st == S_FIRST) low_q <= mem_rdata;
    end
  end

  always_comb begin
    case (off_q)
      2'd1:    joined = {mem_rdata[7:0],  low_q[31:8]};
      2'd2:    joined = {mem_rdata[15:0], low_q[31:16]};
      2'd3:    joined = {mem_rdata[23:0], low_q[31:24]};
      default: joined = low_q;
    endcase
  end

  assign rsp_valid = st == S_ONE || st == S_SECOND || st == S_FLT;
  assign rsp_fault = st == S_FLT;
  assign rsp_count = (st == S_ONE) ? 2'd1 : (st == S_SECOND) ? 2'd2 : 2'd0;
  assign rsp_data  = (st == S_ONE) ? mem_rdata : (st == S_SECOND) ? joined : 32'd0;

  assert_reset_idle_R1: assert property (@(posedge clk) !rst_n |-> req_ready && !rsp_valid && !mem_en);
  assert_single_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_count == 2'd1 |-> $past(mem_en) && !mem_en);
  assert_two_reads_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_count == 2'd2 |-> $past(mem_en) && $past(mem_en, 2));
  assert_next_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en && $past(mem_en) |-> mem_addr == $past(mem_addr) + 14'd1);
  assert_fault_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> !mem_en && $past(!mem_en) && rsp_data == 32'd0 && rsp_count == 2'd0);
  assert_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  assert_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
endmodule

// File: tb/test_split_load_unit.sv
`timescale 1ns/1ps
module test_split_load_unit;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0;
  logic        req_ready;
  logic [15:0] req_addr = 0;
  logic [1:0]  req_mode = 0;
  logic        mem_en;
  logic [13:0] mem_addr;
  logic [31:0] mem_rdata = 0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        rsp_fault;
  logic [1:0]  rsp_count;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  int acc_cnt = 0;
  logic [13:0] acc_addr [2];

  always #2.5 clk = ~clk;

  split_load_unit i_split_load_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_mode(req_mode), .mem_en(mem_en), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_fault(rsp_fault), .rsp_count(rsp_count));

  function automatic logic [31:0] word_of(input logic [13:0] c);
    return (32'h9E3779B1 * {18'd0, c}) ^ {c, 18'h2B3C5};
  endfunction

  function automatic logic [7:0] byte_of(input logic [15:0] a);
    logic [31:0] w;
    w = word_of(a[15:2]);
    return w[8*a[1:0] +: 8];
  endfunction

  always_ff @(posedge clk) if (mem_en) mem_rdata <= word_of(mem_addr);

  always @(posedge clk) if (mem_en) begin
    if (acc_cnt < 2) acc_addr[acc_cnt] = mem_addr;
    acc_cnt = acc_cnt + 1;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_load(input logic [15:0] a, input logic [1:0] m);
    logic [31:0] exp_d;
    int exp_lat, exp_acc, lat;
    bit misal;
    misal = a[1:0] != 0;
    if (!misal) begin exp_d = word_of(a[15:2]); exp_lat = 1; exp_acc = 1; end
    else if (m == 2'b01) begin exp_d = 0; exp_lat = 1; exp_acc = 0; end
    else if (m[1]) begin exp_d = word_of(a[15:2]); exp_lat = 1; exp_acc = 1; end
    else begin
      exp_d = {byte_of(a + 16'd3), byte_of(a + 16'd2), byte_of(a + 16'd1), byte_of(a)};
      exp_lat = 2; exp_acc = 2;
    end
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_addr = a; req_mode = m; req_valid = 1; acc_cnt = 0;
    @(posedge clk);
    #1;
    req_valid = 0;
    req_addr = 16'($urandom);
    req_mode = 2'($urandom);
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      if (!rsp_valid) check(!req_ready, "R7 ready low while busy", {31'd0, req_ready}, 0);
    end while (!rsp_valid && lat < 4);
    check(lat == exp_lat, misal ? (m == 0 ? "R3 latency" : "R5/R6 latency") : "R2 latency", lat, exp_lat);
    check(rsp_data == exp_d, misal && m == 0 ? "R4 R9 merged data" : "R2 R6 data", rsp_data, exp_d);
    check(rsp_fault == (misal && m == 2'b01), "R5 fault flag", {31'd0, rsp_fault}, {31'd0, misal && m == 2'b01});
    check(rsp_count == 2'(exp_acc), "R2 R3 R5 count", {30'd0, rsp_count}, exp_acc);
    check(acc_cnt == exp_acc, "R3 R5 memory reads", acc_cnt, exp_acc);
    if (exp_acc >= 1) check(acc_addr[0] == a[15:2], "R6 R9 first word", {18'd0, acc_addr[0]}, {18'd0, a[15:2]});
    if (exp_acc == 2) check(acc_addr[1] == a[15:2] + 14'd1, "R8 second word", {18'd0, acc_addr[1]}, {18'd0, a[15:2] + 14'd1});
    @(negedge clk);
    check(!rsp_valid && req_ready, "R7 single pulse then idle", {30'd0, rsp_valid, req_ready}, 1);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 1, 0);
    finish_up();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(req_ready && !rsp_valid && !mem_en, "R1 reset state", {29'd0, req_ready, rsp_valid, mem_en}, 3'b100);
    rst_n = 1;
    @(negedge clk);
    check(req_ready && !rsp_valid && !mem_en, "R1 after reset", {29'd0, req_ready, rsp_valid, mem_en}, 3'b100);
    run_load(16'h0100, 2'b00);
    run_load(16'h0100, 2'b01);
    run_load(16'h0100, 2'b10);
    for (int k = 1; k < 4; k++) run_load(16'h2340 + 16'(k), 2'b00);
    run_load(16'h1233, 2'b01);
    run_load(16'h1231, 2'b10);
    run_load(16'h1232, 2'b11);
    run_load(16'hFFFD, 2'b00);
    run_load(16'hFFFE, 2'b00);
    run_load(16'hFFFF, 2'b00);
    run_load(16'hFFFC, 2'b00);
    for (int n = 0; n < 300; n++) run_load(16'($urandom), 2'($urandom));
    finish_up();
  end
endmodule